// File: doc/BRIEF.md
# Detour-Aware Mesh Route Computation

This block is the route-compute stage of a two-dimensional mesh router whose neighbours may be switched off. For each packet header it receives the router's own column and row, the destination column and row, a liveness bit for each of the four neighbours, the input port the header arrived on, and a two-bit detour tag from the header. It returns the output port to use, the tag to write into the outgoing header, and a stall flag when no legal live port exists.

Routing is dimension-ordered when the path is clear. When the neighbour needed for the column hop is dead, the packet is stepped up or down a row to get around it. When the neighbour needed for the row hop is dead, the packet, already in its column, is stepped sideways. A router taking either detour marks the packet. A marked packet is never sent back out of the port it came in on, so detouring routers cannot bounce it between each other. Row 0 is the north edge and column 0 the west edge.

Headers enter on a valid/ready interface and results leave on a second valid/ready interface through one register stage. A header is taken on any clock edge where `hdr_valid` and `hdr_ready` are both high. `hdr_ready` is high when the result register is empty or is being drained in that same cycle. A result stays unchanged while `res_valid` is high and `res_ready` is low.

Top module: `sxy_route_unit`

## Requirements
- R1: When the destination column and row equal the router's own, the result is port 0 (local) with tag 00.
- R2: When the destination column differs, the preferred port is East (code 2) if the destination column is larger and West (code 4) if it is smaller. If that neighbour is live (liveness bit index = port code minus 1: bit0 North, bit1 East, bit2 South, bit3 West), it is chosen with tag 00.
- R3: When the columns match and the rows differ, the preferred port is South (code 3) if the destination row is larger and North (code 1) if it is smaller. If that neighbour is live, it is chosen with tag 00.
- R4: When the R2 port is unusable, the block detours with tag 01. It prefers North if the destination row is less than or equal to the current row and South otherwise. It falls back to the other vertical port when the preferred one is dead, beyond the mesh edge, or disallowed by R6.
- R5: When the R3 port is unusable, the block steps sideways with tag 10. It takes East unless the router is in the last column or East is dead, and otherwise takes West.
- R6: A packet whose incoming tag is non-zero is never routed to the port code equal to its input port. An unmarked packet (tag 00) may be.
- R7: A marked packet whose preferred dimension-order port is usable leaves with tag 00.
- R8: When no usable port exists, the stall flag is 1, the port reads 7, and the tag is passed through unchanged.
- R9: The result appears one clock after acceptance. While `res_valid` is high and `res_ready` is low, `hdr_ready` is low and all result outputs hold.
- R10: After reset, `res_valid` is 0 and `hdr_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hdr_valid | input | 1 | Header present |
| hdr_ready | output | 1 | Header accepted this cycle when valid |
| here_x | input | XW | Router column |
| here_y | input | YW | Router row |
| dest_x | input | XW | Destination column |
| dest_y | input | YW | Destination row |
| tag_in | input | 2 | Detour tag from header |
| from_port | input | 3 | Port the header arrived on (0..4) |
| nbr_live | input | 4 | Neighbour liveness, bit0 N, bit1 E, bit2 S, bit3 W |
| res_valid | output | 1 | Result present |
| res_ready | input | 1 | Downstream takes result |
| res_port | output | 3 | 0 local, 1 N, 2 E, 3 S, 4 W, 7 none |
| res_tag | output | 2 | Tag for outgoing header |
| res_stall | output | 1 | No usable port |

## Verification
Clear-path headers aimed at each of the four directions and at the router itself show whether column-before-row ordering and the compare directions are right. Killing the column neighbour with destinations above, level with and below the router, and at the north mesh edge, separates the vertical preference from its fallback and from the edge check. Killing the row neighbour in an interior column and in the last column separates the East default from the West fallback. Marked and unmarked headers from the same input port, plus a fully blocked case and a held result under back-pressure, tell apart the no-return rule, tag clearing, stall reporting and hold behaviour.

// File: rtl/sxy_pkg.sv
package sxy_pkg;
  localparam logic [2:0] PORT_LOCAL = 3'd0;
  localparam logic [2:0] PORT_N     = 3'd1;
  localparam logic [2:0] PORT_E     = 3'd2;
  localparam logic [2:0] PORT_S     = 3'd3;
  localparam logic [2:0] PORT_W     = 3'd4;
  localparam logic [2:0] PORT_NONE  = 3'd7;

  localparam logic [1:0] TAG_PLAIN = 2'b00;
  localparam logic [1:0] TAG_HORZ  = 2'b01;
  localparam logic [1:0] TAG_VERT  = 2'b10;

  typedef struct packed {
    logic       stall;
    logic [1:0] tag;
    logic [2:0] port;
  } route_res_t;
endpackage

// File: rtl/sxy_route_calc.sv
module sxy_route_calc
  import sxy_pkg::*;
#(
  parameter int MESH_COLS = 4,
  parameter int MESH_ROWS = 4,
  parameter int XW = $clog2(MESH_COLS),
  parameter int YW = $clog2(MESH_ROWS)
) (
  input  logic [XW-1:0] cx,
  input  logic [YW-1:0] cy,
  input  logic [XW-1:0] dx,
  input  logic [YW-1:0] dy,
  input  logic [1:0]    tag_i,
  input  logic [2:0]    from_i,
  input  logic [3:0]    live_i,
  output route_res_t    res_o
);
  localparam logic [XW-1:0] LAST_COL = XW'(MESH_COLS - 1);
  localparam logic [YW-1:0] LAST_ROW = YW'(MESH_ROWS - 1);

  logic       marked;
  logic [4:1] usable;

  assign marked = (tag_i != TAG_PLAIN);

  // a direction is usable when live, inside the mesh and not a return hop
  always_comb begin
    usable[1] = live_i[0] && (cy != '0);
    usable[2] = live_i[1] && (cx != LAST_COL);
    usable[3] = live_i[2] && (cy != LAST_ROW);
    usable[4] = live_i[3] && (cx != '0);
    for (int d = 1; d <= 4; d++) begin
      if (marked && (from_i == 3'(d))) usable[d] = 1'b0;
    end
  end

  logic [2:0] pref_x, pref_y, side_a, side_b;

  always_comb begin
    pref_x = (dx > cx) ? PORT_E : PORT_W;
    pref_y = (dy > cy) ? PORT_S : PORT_N;
    side_a = (dy <= cy) ? PORT_N : PORT_S;
    side_b = (dy <= cy) ? PORT_S : PORT_N;
  end

  always_comb begin
    res_o.stall = 1'b0;
    res_o.tag   = TAG_PLAIN;
    res_o.port  = PORT_LOCAL;
    if (dx == cx && dy == cy) begin
      res_o.port = PORT_LOCAL;
    end else if (dx != cx) begin
      if (usable[pref_x])      res_o.port = pref_x;
      else if (usable[side_a]) begin res_o.port = side_a; res_o.tag = TAG_HORZ; end
      else if (usable[side_b]) begin res_o.port = side_b; res_o.tag = TAG_HORZ; end
      else begin res_o.port = PORT_NONE; res_o.stall = 1'b1; res_o.tag = tag_i; end
    end else begin
      if (usable[pref_y])      res_o.port = pref_y;
      else if (usable[PORT_E]) begin res_o.port = PORT_E; res_o.tag = TAG_VERT; end
      else if (usable[PORT_W]) begin res_o.port = PORT_W; res_o.tag = TAG_VERT; end
      else begin res_o.port = PORT_NONE; res_o.stall = 1'b1; res_o.tag = tag_i; end
    end
  end
endmodule

// File: rtl/sxy_hold_reg.sv
module sxy_hold_reg #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_data <= in_data;
    end
  end

  AST_HOLD_UNDER_BP: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data)); // R9
  AST_ACCEPT_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid); // R9
endmodule

// File: rtl/sxy_route_unit.sv
module sxy_route_unit
  import sxy_pkg::*;
#(
  parameter int MESH_COLS = 4,
  parameter int MESH_ROWS = 4,
  parameter int XW = $clog2(MESH_COLS),
  parameter int YW = $clog2(MESH_ROWS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hdr_valid,
  output logic          hdr_ready,
  input  logic [XW-1:0] here_x,
  input  logic [YW-1:0] here_y,
  input  logic [XW-1:0] dest_x,
  input  logic [YW-1:0] dest_y,
  input  logic [1:0]    tag_in,
  input  logic [2:0]    from_port,
  input  logic [3:0]    nbr_live,
  output logic          res_valid,
  input  logic          res_ready,
  output logic [2:0]    res_port,
  output logic [1:0]    res_tag,
  output logic          res_stall
);
  localparam int RW = $bits(route_res_t);

  route_res_t calc_res, held_res;

  sxy_route_calc #(
    .MESH_COLS(MESH_COLS), .MESH_ROWS(MESH_ROWS), .XW(XW), .YW(YW)
  ) u_calc (
    .cx(here_x), .cy(here_y), .dx(dest_x), .dy(dest_y),
    .tag_i(tag_in), .from_i(from_port), .live_i(nbr_live),
    .res_o(calc_res)
  );

  logic [RW-1:0] held_bits;

  sxy_hold_reg #(.W(RW)) u_hold (
    .clk(clk), .rst_n(rst_n),
    .in_valid(hdr_valid), .in_ready(hdr_ready), .in_data(calc_res),
    .out_valid(res_valid), .out_ready(res_ready), .out_data(held_bits)
  );

  assign held_res  = route_res_t'(held_bits);
  assign res_port  = held_res.port;
  assign res_tag   = held_res.tag;
  assign res_stall = held_res.stall;

  AST_STALL_NO_PORT: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_stall |-> res_port == PORT_NONE); // R8
  AST_NO_BOUNCE: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_valid && hdr_ready && tag_in != TAG_PLAIN |=> res_port != $past(from_port)); // R6
  AST_LOCAL_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_port == PORT_LOCAL |-> res_tag == TAG_PLAIN); // R1
  AST_BLOCK_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |-> !hdr_ready); // R9
endmodule

// File: tb/sxy_route_unit_test.sv
module sxy_route_unit_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic       hdr_valid = 1'b0, hdr_ready, res_valid, res_ready = 1'b1, res_stall;
  logic [1:0] here_x = '0, here_y = '0, dest_x = '0, dest_y = '0;
  logic [1:0] tag_in = '0, res_tag;
  logic [2:0] from_port = '0, res_port;
  logic [3:0] nbr_live = 4'hF;

  int total = 0, bad = 0;

  sxy_route_unit uut (
    .clk(clk), .rst_n(rst_n), .hdr_valid(hdr_valid), .hdr_ready(hdr_ready),
    .here_x(here_x), .here_y(here_y), .dest_x(dest_x), .dest_y(dest_y),
    .tag_in(tag_in), .from_port(from_port), .nbr_live(nbr_live),
    .res_valid(res_valid), .res_ready(res_ready), .res_port(res_port),
    .res_tag(res_tag), .res_stall(res_stall)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one header, one result, checked one clock after acceptance
  task automatic route(input string req, input int cx, input int cy, input int dx,
                       input int dy, input int tg, input int fp, input logic [3:0] lv,
                       input int ep, input int et, input int es);
    @(negedge clk);
    here_x = 2'(cx); here_y = 2'(cy); dest_x = 2'(dx); dest_y = 2'(dy);
    tag_in = 2'(tg); from_port = 3'(fp); nbr_live = lv; hdr_valid = 1'b1;
    @(negedge clk);
    hdr_valid = 1'b0;
    chk({req, " valid"}, int'(res_valid), 1);
    chk({req, " port"}, int'(res_port), ep);
    chk({req, " tag"}, int'(res_tag), et);
    chk({req, " stall"}, int'(res_stall), es);
  endtask

  task automatic t_reset;
    chk("R10 res_valid", int'(res_valid), 0);
    chk("R10 hdr_ready", int'(hdr_ready), 1);
  endtask

  task automatic t_backpressure;
    @(negedge clk);
    res_ready = 1'b0;
    here_x = 2'd1; here_y = 2'd1; dest_x = 2'd3; dest_y = 2'd1;
    tag_in = 2'd0; from_port = 3'd0; nbr_live = 4'hF; hdr_valid = 1'b1;
    @(negedge clk);
    chk("R9 first port", int'(res_port), 2);
    chk("R9 ready low", int'(hdr_ready), 0);
    dest_x = 2'd0;
    @(negedge clk);
    chk("R9 held port", int'(res_port), 2);
    chk("R9 held valid", int'(res_valid), 1);
    res_ready = 1'b1;
    @(negedge clk);
    hdr_valid = 1'b0;
    chk("R9 second port", int'(res_port), 4);
    @(negedge clk);
    chk("R9 drained", int'(res_valid), 0);
  endtask

  initial begin
    #3000000;
    bad++; total++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1;
    t_reset();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    route("R1 local",        1, 1, 1, 1, 0, 0, 4'hF, 0, 0, 0);
    route("R2 east",         1, 1, 3, 0, 0, 0, 4'hF, 2, 0, 0);
    route("R2 west",         1, 1, 0, 2, 0, 0, 4'hF, 4, 0, 0);
    route("R3 south",        1, 1, 1, 3, 0, 0, 4'hF, 3, 0, 0);
    route("R3 north",        1, 1, 1, 0, 0, 0, 4'hF, 1, 0, 0);
    route("R4 level north",  1, 1, 3, 1, 0, 0, 4'b1101, 1, 1, 0);
    route("R4 below south",  1, 1, 3, 2, 0, 0, 4'b1101, 3, 1, 0);
    route("R4 fallback",     1, 1, 3, 2, 0, 0, 4'b1001, 1, 1, 0);
    route("R4 north edge",   1, 0, 3, 0, 0, 0, 4'b1101, 3, 1, 0);
    route("R5 east side",    1, 1, 1, 3, 0, 0, 4'b1011, 2, 2, 0);
    route("R5 last column",  3, 1, 3, 3, 0, 0, 4'b1011, 4, 2, 0);
    route("R5 east dead",    1, 1, 1, 3, 0, 0, 4'b1001, 4, 2, 0);
    route("R6 marked back",  1, 1, 3, 1, 1, 2, 4'hF, 1, 1, 0);
    route("R6 plain back",   1, 1, 3, 1, 0, 2, 4'hF, 2, 0, 0);
    route("R7 tag cleared",  1, 1, 3, 1, 1, 4, 4'hF, 2, 0, 0);
    route("R8 stall plain",  1, 1, 3, 1, 0, 0, 4'b1000, 7, 0, 1);
    route("R8 stall marked", 1, 1, 1, 3, 2, 4, 4'b1001, 7, 2, 1);
    t_backpressure();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule